// File: doc/BRIEF.md
# Level-Sensitive Interrupt Aggregator with APB Access

This block gathers a configurable number of level-sensitive interrupt lines and reports them to a parent interrupt controller through one combined request. Software on an APB bus decides which lines take part. An enable bit admits a line and a mask bit blocks it. A read-only status view shows the lines that are currently asserted, enabled and not masked. Each of the three register kinds is split into a low and a high 32-bit word, so the block can serve up to 64 lines.

The line count is a parameter from 2 to 64. Register bits for lines above the configured count have no flip-flops behind them and always read zero. Software can therefore write all ones to the enable words and read them back to learn how many lines exist. Incoming lines pass through a two-stage synchronizer before gating. The combined request is the OR of the status bits, registered on the bus clock. Nothing is latched: a status bit follows its synchronized line, and there is nothing for software to clear.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: Enable words are read/write at byte offsets 0x00 (lines 0..31) and 0x04 (lines 32..63). Line n occupies bit n mod 32 of its word. A write takes effect at the clock edge of the access phase.
- R2: Mask words are read/write at offsets 0x08 (low) and 0x0C (high), using the same bit placement. A 1 masks the line and a 0 unmasks it. A masked line never contributes to status or to irq_o.
- R3: Bits for lines at or above NUM_SRC have no storage in any register. After an all-ones write they still read 0. With NUM_SRC=40, the high enable word reads 0x000000FF.
- R4: Status words at offsets 0x30 (low) and 0x34 (high) read as synchronized line AND enable AND NOT mask. A change on src_i shows in the status read two clock edges later.
- R5: Writes to the status offsets and to any unmapped offset leave all registers unchanged. Reads of unmapped offsets return 0.
- R6: Lines are level-sensitive. A status bit clears once its synchronized line drops, with no latching and no write-to-clear.
- R7: irq_o is the OR of all status bits, registered, so it lags status by one clock edge.
- R8: After reset, the enable and mask registers are zero and irq_o is low.
- R9: pready_o is always 1 and pslverr_o is always 0. Accesses have zero wait states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB access phase |
| pwrite_i | input | 1 | APB write strobe |
| paddr_i | input | ADDR_W | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |
| pready_o | output | 1 | Always high |
| pslverr_o | output | 1 | Always low |
| src_i | input | NUM_SRC | Level interrupt lines |
| irq_o | output | 1 | Combined request to the parent controller |

## Verification
Two things can land on the same clock edge: a line change that reaches the synchronizer output, and an APB write that changes the enable or mask word gating that line. The bench provokes this by toggling lines every cycle while it rewrites the mask and enable words. A behavioural model predicts irq_o on every clock, and every status read is compared against the same model. A wrong ordering between the register update and the gating shows up as a one-cycle mismatch on irq_o.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned MAX_SRC = 64;
  localparam int unsigned WORD_W  = 32;

  localparam logic [11:0] OFS_EN_LO   = 12'h000;
  localparam logic [11:0] OFS_EN_HI   = 12'h004;
  localparam logic [11:0] OFS_MASK_LO = 12'h008;
  localparam logic [11:0] OFS_MASK_HI = 12'h00C;
  localparam logic [11:0] OFS_FS_LO   = 12'h030;
  localparam logic [11:0] OFS_FS_HI   = 12'h034;

  function automatic logic [MAX_SRC-1:0] impl_bits(int unsigned n);
    logic [MAX_SRC-1:0] v;
    v = '0;
    for (int unsigned i = 0; i < MAX_SRC; i++) v[i] = (i < n);
    return v;
  endfunction
endpackage

// File: rtl/irq_agg_sync.sv
module irq_agg_sync #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/irq_agg_regs.sv
module irq_agg_regs
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned ADDR_W  = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [WORD_W-1:0]  wdata_i,
  output logic [MAX_SRC-1:0] en_o,
  output logic [MAX_SRC-1:0] mask_o
);
  localparam logic [MAX_SRC-1:0] IMPL = impl_bits(NUM_SRC);
  localparam int unsigned NWORDS = MAX_SRC / WORD_W;

  logic [MAX_SRC-1:0] en_q, mask_q;

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_EN_LO)   + ADDR_W'(4 * w);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK_LO) + ADDR_W'(4 * w);
    localparam logic [WORD_W-1:0] KEEP   = IMPL[w*WORD_W +: WORD_W];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q[w*WORD_W +: WORD_W]   <= '0;
        mask_q[w*WORD_W +: WORD_W] <= '0;
      end else if (wr_i) begin
        if (addr_i == A_EN)   en_q[w*WORD_W +: WORD_W]   <= wdata_i & KEEP;
        if (addr_i == A_MASK) mask_q[w*WORD_W +: WORD_W] <= wdata_i & KEEP;
      end
    end

    AST_EN_WORD_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && addr_i == A_EN) |=> en_q[w*WORD_W +: WORD_W] == ($past(wdata_i) & KEEP)); // R1
    AST_MASK_WORD_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && addr_i == A_MASK) |=> mask_q[w*WORD_W +: WORD_W] == ($past(wdata_i) & KEEP)); // R2
  end

  assign en_o   = en_q;
  assign mask_o = mask_q;

  AST_RO_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (addr_i == ADDR_W'(OFS_FS_LO) || addr_i == ADDR_W'(OFS_FS_HI)))
      |=> ($stable(en_q) && $stable(mask_q))); // R5
  AST_ABSENT_BITS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (((en_q | mask_q) & ~IMPL) == '0)); // R3
endmodule

// File: rtl/irq_agg_gate.sv
module irq_agg_gate
  import irq_agg_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [MAX_SRC-1:0] raw_i,
  input  logic [MAX_SRC-1:0] en_i,
  input  logic [MAX_SRC-1:0] mask_i,
  output logic [MAX_SRC-1:0] status_o,
  output logic               irq_o
);
  logic irq_q;

  assign status_o = raw_i & en_i & ~mask_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |status_o;
  end

  assign irq_o = irq_q;

  AST_IRQ_LAGS_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(|status_o))); // R7
  AST_QUIET_LINES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_i == '0) |=> !irq_o); // R6
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned ADDR_W  = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               psel_i,
  input  logic               penable_i,
  input  logic               pwrite_i,
  input  logic [ADDR_W-1:0]  paddr_i,
  input  logic [WORD_W-1:0]  pwdata_i,
  output logic [WORD_W-1:0]  prdata_o,
  output logic               pready_o,
  output logic               pslverr_o,
  input  logic [NUM_SRC-1:0] src_i,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] src_sync;
  logic [MAX_SRC-1:0] raw_w, en_w, mask_w, status_w;
  logic               wr_w, hit_w;
  logic [WORD_W-1:0]  rdata_w;

  assign wr_w  = psel_i && penable_i && pwrite_i;
  assign raw_w = MAX_SRC'(src_sync);

  irq_agg_sync #(.W(NUM_SRC)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (src_i),
    .q_o   (src_sync)
  );

  irq_agg_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_w),
    .addr_i (paddr_i),
    .wdata_i(pwdata_i),
    .en_o   (en_w),
    .mask_o (mask_w)
  );

  irq_agg_gate u_gate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .raw_i   (raw_w),
    .en_i    (en_w),
    .mask_i  (mask_w),
    .status_o(status_w),
    .irq_o   (irq_o)
  );

  always_comb begin
    rdata_w = '0;
    hit_w   = 1'b1;
    case (paddr_i)
      ADDR_W'(OFS_EN_LO):   rdata_w = en_w[31:0];
      ADDR_W'(OFS_EN_HI):   rdata_w = en_w[63:32];
      ADDR_W'(OFS_MASK_LO): rdata_w = mask_w[31:0];
      ADDR_W'(OFS_MASK_HI): rdata_w = mask_w[63:32];
      ADDR_W'(OFS_FS_LO):   rdata_w = status_w[31:0];
      ADDR_W'(OFS_FS_HI):   rdata_w = status_w[63:32];
      default:              hit_w   = 1'b0;
    endcase
  end

  assign prdata_o  = (psel_i && !pwrite_i) ? rdata_w : '0;
  assign pready_o  = 1'b1;
  assign pslverr_o = 1'b0;

  AST_STATUS_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_w & ~(en_w & ~mask_w)) == '0); // R4
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_i && !pwrite_i && !hit_w) |-> (prdata_o == '0)); // R5
endmodule

// File: tb/lvl_irq_ctrl_test.sv
`timescale 1ns/1ps
module lvl_irq_ctrl_test;
  localparam int N  = 40;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [31:0]   pwdata = '0;
  logic [31:0]   prdata;
  logic          pready, pslverr, irq;
  logic [N-1:0]  src = '0;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  lvl_irq_ctrl #(.NUM_SRC(N), .ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
    .pready_o(pready), .pslverr_o(pslverr), .src_i(src), .irq_o(irq)
  );

  // Behavioural reference: per-line bit arrays and a two-deep delay queue
  bit m_en[64];
  bit m_mask[64];
  bit m_irq;
  logic [63:0] line_q[$];

  function automatic bit line_status(int i);
    logic [63:0] synced;
    synced = line_q[0];
    return synced[i] && m_en[i] && !m_mask[i];
  endfunction

  function automatic logic [31:0] model_read(logic [AW-1:0] a);
    logic [31:0] v;
    int base;
    v = '0;
    base = (a == 12'h004 || a == 12'h00C || a == 12'h034) ? 32 : 0;
    for (int b = 0; b < 32; b++) begin
      case (a)
        12'h000, 12'h004: v[b] = m_en[base + b];
        12'h008, 12'h00C: v[b] = m_mask[base + b];
        12'h030, 12'h034: v[b] = line_status(base + b);
        default:          v[b] = 1'b0;
      endcase
    end
    return v;
  endfunction

  initial begin
    for (int i = 0; i < 64; i++) begin
      m_en[i] = 0;
      m_mask[i] = 0;
    end
    m_irq = 0;
    line_q.push_back('0);
    line_q.push_back('0);
  end

  always @(posedge clk) begin
    if (rst_n) begin
      bit any;
      any = 0;
      for (int i = 0; i < 64; i++) any |= line_status(i);
      m_irq = any;
      if (psel && penable && pwrite) begin
        for (int b = 0; b < 32; b++) begin
          case (paddr)
            12'h000: if (b < N)      m_en[b]        = pwdata[b];
            12'h004: if (b + 32 < N) m_en[b + 32]   = pwdata[b];
            12'h008: if (b < N)      m_mask[b]      = pwdata[b];
            12'h00C: if (b + 32 < N) m_mask[b + 32] = pwdata[b];
            default: ;
          endcase
        end
      end
      void'(line_q.pop_front());
      line_q.push_back(64'(src));
    end
  end

  // Per-cycle comparison on the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (irq !== m_irq) begin
        errors++;
        $display("FAIL R7 irq_o actual=%0b expected=%0b at %0t", irq, m_irq, $time);
      end
      checks++;
      if (pready !== 1'b1 || pslverr !== 1'b0) begin
        errors++;
        $display("FAIL R9 pready/pslverr actual=%0b/%0b expected=1/0", pready, pslverr);
      end
    end
  end

  task automatic apb_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk);
    penable = 1;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic check_val(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apb_read(input logic [AW-1:0] a, input string req, output logic [31:0] d);
    @(negedge clk);
    psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk);
    penable = 1;
    #1;
    d = prdata;
    check_val(req, d, model_read(a));
    @(negedge clk);
    psel = 0; penable = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    idle(3);
    check_val("R8 irq_o in reset", {31'b0, irq}, 32'h0);
    rst_n = 1;
    idle(2);
    apb_read(12'h000, "R8 enable lo reset", d);  check_val("R8 enable lo", d, 32'h0);
    apb_read(12'h004, "R8 enable hi reset", d);  check_val("R8 enable hi", d, 32'h0);
    apb_read(12'h008, "R8 mask lo reset", d);    check_val("R8 mask lo", d, 32'h0);
    apb_read(12'h00C, "R8 mask hi reset", d);    check_val("R8 mask hi", d, 32'h0);

    // R3: line-count discovery
    apb_write(12'h000, 32'hFFFF_FFFF);
    apb_write(12'h004, 32'hFFFF_FFFF);
    apb_write(12'h00C, 32'hFFFF_FFFF);
    apb_read(12'h004, "R3 enable hi after ones", d); check_val("R3 enable hi count", d, 32'h0000_00FF);
    apb_read(12'h00C, "R3 mask hi after ones", d);   check_val("R3 mask hi count", d, 32'h0000_00FF);
    apb_read(12'h000, "R1 enable lo after ones", d); check_val("R1 enable lo ones", d, 32'hFFFF_FFFF);

    // R1 / R2: arbitrary patterns
    apb_write(12'h000, 32'hA5A5_5A5A);
    apb_read(12'h000, "R1 enable lo pattern", d); check_val("R1 enable lo value", d, 32'hA5A5_5A5A);
    apb_write(12'h00C, 32'h0000_0012);
    apb_read(12'h00C, "R2 mask hi pattern", d);   check_val("R2 mask hi value", d, 32'h0000_0012);

    // R4 / R7: gating
    apb_write(12'h000, 32'hFFFF_FFFF);
    apb_write(12'h008, 32'h0000_0000);
    apb_write(12'h00C, 32'h0000_0000);
    @(negedge clk); src = 40'h80_0000_0001;
    idle(4);
    apb_read(12'h030, "R4 status lo", d); check_val("R4 status lo bit0", d, 32'h0000_0001);
    apb_read(12'h034, "R4 status hi", d); check_val("R4 status hi bit39", d, 32'h0000_0080);
    check_val("R7 irq asserted", {31'b0, irq}, 32'h1);

    // R2: mask suppresses
    apb_write(12'h008, 32'h0000_0001);
    apb_write(12'h00C, 32'h0000_0080);
    idle(2);
    apb_read(12'h030, "R2 masked status lo", d); check_val("R2 masked lo", d, 32'h0);
    check_val("R2 irq masked", {31'b0, irq}, 32'h0);
    apb_write(12'h008, 32'h0);
    apb_write(12'h00C, 32'h0);

    // R6: level, no latching
    @(negedge clk); src = '0;
    idle(4);
    apb_read(12'h030, "R6 status clears lo", d); check_val("R6 cleared lo", d, 32'h0);
    apb_read(12'h034, "R6 status clears hi", d); check_val("R6 cleared hi", d, 32'h0);
    check_val("R6 irq drops", {31'b0, irq}, 32'h0);

    // R5: read-only and unmapped
    apb_write(12'h030, 32'hFFFF_FFFF);
    apb_write(12'h034, 32'hFFFF_FFFF);
    apb_write(12'h020, 32'hFFFF_FFFF);
    apb_read(12'h008, "R5 mask lo untouched", d); check_val("R5 mask lo zero", d, 32'h0);
    apb_read(12'h004, "R5 enable hi untouched", d);
    apb_read(12'h020, "R5 unmapped read", d);     check_val("R5 unmapped zero", d, 32'h0);
    apb_read(12'h002, "R5 unaligned read", d);    check_val("R5 unaligned zero", d, 32'h0);

    // Concurrency: lines toggle every cycle while gating is rewritten
    fork
      begin
        for (int k = 0; k < 120; k++) begin
          @(negedge clk);
          src = N'({$urandom, $urandom});
        end
      end
      begin
        for (int k = 0; k < 10; k++) begin
          apb_write(12'h008, $urandom);
          apb_write(12'h004, $urandom);
          apb_read(12'h030, "R4 status under traffic", d);
          apb_read(12'h034, "R4 status hi under traffic", d);
        end
      end
    join
    @(negedge clk); src = '0;
    idle(5);
    check_val("R6 final quiet irq", {31'b0, irq}, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule